// File: doc/BRIEF.md
# Two-Wire Framed Register Link

This block is the device side of a two-wire serial access port. One wire is a clock that the host toggles; the other carries data in both directions. Every transfer is a fixed 21-bit frame, sent least significant bit first. Each frame begins and ends with a '1' marker and is protected by two parity bits. One parity bit covers the even bit positions and the other covers the odd bit positions. The block samples the host's clock and data with the fast system clock, rebuilds each frame and checks it. Command frames are decoded into an operation and a 6-bit address. The block then moves the data frames that follow between the wire and an external 64-word by 16-bit register port.

The supported operations are single, continuous and block reads and writes, and an exit command. Block transfers step the address and stop on their own after the address whose low three bits are all ones. The first valid command must arrive within a power-up window, which is counted in ticks of a free-running timebase. Any malformed frame, or a missed window, locks the port until reset. The output driver enable stays on through the very first frame. After that it drops while the host is sending a frame and is on between frames and while the block sends read frames. The pad itself is outside the block, so the enable and the output value are separate ports.

Top module: `tw_reg_link`

## Requirements
- R1: A frame is 21 bits, transferred least significant bit first, one bit per rising edge of `sclk`. Received bits are taken from `sd_in` as it stood at that edge.
- R2: A received frame is rejected if bit 0 or bit 20 is not '1', or if the XOR of the even-indexed bits (0..20) or the XOR of the odd-indexed bits (1..19) is not zero. Bits 17 and 18 are the parity bits. A rejected frame, or a data frame where a command is expected, sets `locked`=1 and `intf_mode`=0 permanently until reset.
- R3: A command frame has bit 19='1', command code in bits 6..1, address in bits 14..9, bit 7='0', bit 8='1' and bits 16..15='00'. Any other fixed-bit value, or a code outside {0x00,0x01,0x02,0x03,0x09,0x0A,0x0B}, locks the port.
- R4: Command 0x01 causes exactly one read frame. That frame has bit 0='1', bits 16..1 = the word at the address, bits 19..17 = address bits 2..0, and bit 20='1'. The next frame is then taken as a command.
- R5: Command 0x02 returns read frames for the same address indefinitely. The address never changes, and only reset leaves this state.
- R6: Command 0x03 returns read frames with the address increasing after each one. It ends after the frame for an address whose bits 2..0 are 111, after which a new command is accepted.
- R7: Command 0x09 must be followed by exactly one data frame (bit 19='0', data in bits 16..1). That frame produces a single one-cycle `reg_we` pulse with `reg_addr` and `reg_wdata`. A command frame in its place locks the port.
- R8: Command 0x0A writes every following data frame to the same address until a new command frame arrives. That command frame is then executed.
- R9: Command 0x0B writes each data frame and then increments the address. It ends after writing an address whose bits 2..0 are 111, so a further data frame then locks the port. A command frame ends it early.
- R10: Command 0x00 sets `intf_mode`=0 with `locked`=0. Later frames cause no register writes until reset.
- R11: If no valid first command completes within WIN_TICKS pulses of `tick` after reset, `locked` becomes 1. Later frames cause no writes.
- R12: `sd_oe` is 1 out of reset and throughout the first frame. Once in interface mode it is 0 while a host frame is being received, and 1 between frames and during read frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| tick | input | 1 | Free-running timebase pulse for the power-up window |
| sclk | input | 1 | Serial clock from the host (idle high) |
| sd_in | input | 1 | Serial data from the host |
| sd_out | output | 1 | Serial data driven by the block (idle '1') |
| sd_oe | output | 1 | Output driver enable for the data wire |
| intf_mode | output | 1 | Interface mode is active |
| locked | output | 1 | Port locked by a bad frame or a missed window |
| reg_addr | output | 6 | Register port address |
| reg_wdata | output | 16 | Register port write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 16 | Register port read data, combinational from `reg_addr` |

## Verification
The bench builds the block with WIN_TICKS=300 and SYNC_STAGES=2, and pulses `tick` every second clock. The power-up window therefore lasts about 600 cycles. That is long enough for a first frame of about 220 cycles, yet short enough for window expiry to be seen directly. It is also short enough for the run to include many resets for the lock, exit and continuous-read cases. The 64-word bench memory lets random block transfers start from any address and cross every 8-word boundary. The slow serial bit period of ten system clocks covers the synchronizer delay and the read-data fetch between frames.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int FRAME_W = 21;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 6;
  localparam int SUB_W   = 3;

  typedef enum logic [2:0] {
    ST_WAIT, ST_CMD, ST_WDATA, ST_RDATA, ST_EXIT, ST_LOCK
  } link_state_e;

  typedef enum logic [2:0] {
    OP_RD1, OP_RDC, OP_RDB, OP_WR1, OP_WRC, OP_WRB
  } link_op_e;

  localparam logic [5:0] CODE_EXIT = 6'h00;
  localparam logic [5:0] CODE_RD1  = 6'h01;
  localparam logic [5:0] CODE_RDC  = 6'h02;
  localparam logic [5:0] CODE_RDB  = 6'h03;
  localparam logic [5:0] CODE_WR1  = 6'h09;
  localparam logic [5:0] CODE_WRC  = 6'h0A;
  localparam logic [5:0] CODE_WRB  = 6'h0B;

  // Markers at both ends, zero XOR over even and over odd positions.
  function automatic logic frame_good(input logic [FRAME_W-1:0] f);
    logic ev, od;
    ev = 1'b0;
    od = 1'b0;
    for (int i = 0; i < FRAME_W; i++) begin
      if (i % 2 == 0) ev ^= f[i];
      else            od ^= f[i];
    end
    return f[0] & f[FRAME_W-1] & ~ev & ~od;
  endfunction
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic sd,
  output logic rise,
  output logic sd_s
);
  logic [STAGES:0]   ck_q;
  logic [STAGES-1:0] d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_q <= '1;
      d_q  <= '0;
    end else begin
      ck_q <= {ck_q[STAGES-1:0], sclk};
      d_q  <= {d_q[STAGES-2:0], sd};
    end
  end

  assign rise = ck_q[STAGES-1] & ~ck_q[STAGES];
  assign sd_s = d_q[STAGES-1];

  // R1: one bit event per serial clock edge
  p_rise_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/tw_rx.sv
module tw_rx
  import tw_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               rise,
  input  logic               din,
  output logic               busy,
  output logic               done,
  output logic [FRAME_W-1:0] frame
);
  localparam int CW = $clog2(FRAME_W);
  localparam logic [CW-1:0] LAST = CW'(FRAME_W - 1);

  logic [CW-1:0]      cnt_q;
  logic [FRAME_W-1:0] sr_q;
  logic               done_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q  <= '0;
      sr_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (rise) begin
        sr_q <= {din, sr_q[FRAME_W-1:1]};
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy  = (cnt_q != '0);
  assign done  = done_q;
  assign frame = sr_q;

  // R1: bit counter never passes the frame length
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  // R1: a frame completes in a single-cycle pulse, counter back at zero
  p_done_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (cnt_q == '0));
endmodule

// File: rtl/tw_tx.sv
module tw_tx
  import tw_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               load,
  input  logic [FRAME_W-1:0] word,
  input  logic               rise,
  output logic               sd_out,
  output logic               done
);
  localparam int CW = $clog2(FRAME_W);
  localparam logic [CW-1:0] LAST = CW'(FRAME_W - 1);

  logic [CW-1:0]      cnt_q;
  logic [FRAME_W-1:0] sr_q;
  logic               done_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q  <= '0;
      sr_q   <= '1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        sr_q  <= word;
        cnt_q <= '0;
      end else if (rise) begin
        sr_q <= {1'b1, sr_q[FRAME_W-1:1]};
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign sd_out = sr_q[0];
  assign done   = done_q;

  // R4: once all bits have left, the line rests at '1'
  p_tx_drained_r4: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (sr_q == '1));
endmodule

// File: rtl/tw_window.sv
module tw_window #(
  parameter int TICKS = 19000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic expired
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (run && tick && cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = (cnt_q == LIMIT);

  // R11: the window counter saturates at its limit
  p_cnt_cap_r11: assert property (@(posedge clk) disable iff (rst)
    expired |=> expired);
endmodule

// File: rtl/tw_reg_link.sv
module tw_reg_link
  import tw_pkg::*;
#(
  parameter int WIN_TICKS   = 19000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              sclk,
  input  logic              sd_in,
  output logic              sd_out,
  output logic              sd_oe,
  output logic              intf_mode,
  output logic              locked,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam logic [SUB_W-1:0] SUB_END = '1;

  link_state_e        state_q;
  link_op_e           op_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic               we_q;
  logic               load_q;
  logic               oe_q;

  logic               bit_rise, bit_val;
  logic               rx_active, rx_busy, rx_done;
  logic [FRAME_W-1:0] rx_frame;
  logic               tx_en, tx_done;
  logic [FRAME_W-1:0] tx_word;
  logic               win_run, win_expired;

  logic               frm_ok, shape_ok, code_known;
  link_state_e        dec_state;
  link_op_e           dec_op;

  tw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk(sclk), .sd(sd_in),
    .rise(bit_rise), .sd_s(bit_val)
  );

  assign rx_active = (state_q == ST_WAIT) || (state_q == ST_CMD) || (state_q == ST_WDATA);

  tw_rx u_rx (
    .clk(clk), .rst(rst), .clr(!rx_active), .rise(bit_rise), .din(bit_val),
    .busy(rx_busy), .done(rx_done), .frame(rx_frame)
  );

  assign tx_en   = (state_q == ST_RDATA);
  assign tx_word = {1'b1, addr_q[SUB_W-1:0], reg_rdata, 1'b1};

  tw_tx u_tx (
    .clk(clk), .rst(rst), .en(tx_en), .load(load_q), .word(tx_word),
    .rise(bit_rise), .sd_out(sd_out), .done(tx_done)
  );

  assign win_run = (state_q == ST_WAIT);

  tw_window #(.TICKS(WIN_TICKS)) u_win (
    .clk(clk), .rst(rst), .run(win_run), .tick(tick), .expired(win_expired)
  );

  // Command decode of the frame just received.
  always_comb begin
    frm_ok     = frame_good(rx_frame);
    shape_ok   = rx_frame[19] & ~rx_frame[7] & rx_frame[8] & (rx_frame[16:15] == 2'b00);
    code_known = 1'b1;
    dec_state  = ST_CMD;
    dec_op     = OP_RD1;
    case (rx_frame[6:1])
      CODE_EXIT: dec_state = ST_EXIT;
      CODE_RD1:  begin dec_state = ST_RDATA; dec_op = OP_RD1; end
      CODE_RDC:  begin dec_state = ST_RDATA; dec_op = OP_RDC; end
      CODE_RDB:  begin dec_state = ST_RDATA; dec_op = OP_RDB; end
      CODE_WR1:  begin dec_state = ST_WDATA; dec_op = OP_WR1; end
      CODE_WRC:  begin dec_state = ST_WDATA; dec_op = OP_WRC; end
      CODE_WRB:  begin dec_state = ST_WDATA; dec_op = OP_WRB; end
      default:   code_known = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_WAIT;
      op_q    <= OP_RD1;
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      load_q  <= 1'b0;
      oe_q    <= 1'b1;
    end else begin
      we_q   <= 1'b0;
      load_q <= 1'b0;
      oe_q   <= !(((state_q == ST_CMD) || (state_q == ST_WDATA)) && rx_busy);
      if (state_q == ST_WAIT && win_expired) begin
        state_q <= ST_LOCK;
      end else if (rx_done && rx_active) begin
        if (!frm_ok) begin
          state_q <= ST_LOCK;
        end else if (!rx_frame[19]) begin
          if (state_q == ST_WDATA) begin
            we_q    <= 1'b1;
            wdata_q <= rx_frame[16:1];
            if (op_q == OP_WR1) state_q <= ST_CMD;
          end else begin
            state_q <= ST_LOCK;
          end
        end else if (state_q == ST_WDATA && op_q == OP_WR1) begin
          state_q <= ST_LOCK;
        end else if (!shape_ok || !code_known) begin
          state_q <= ST_LOCK;
        end else begin
          state_q <= dec_state;
          op_q    <= dec_op;
          addr_q  <= rx_frame[14:9];
          load_q  <= (dec_state == ST_RDATA);
        end
      end else if (tx_done && state_q == ST_RDATA) begin
        case (op_q)
          OP_RDC: load_q <= 1'b1;
          OP_RDB: begin
            if (addr_q[SUB_W-1:0] == SUB_END) begin
              state_q <= ST_CMD;
            end else begin
              addr_q <= addr_q + 1'b1;
              load_q <= 1'b1;
            end
          end
          default: state_q <= ST_CMD;
        endcase
      end else if (we_q && state_q == ST_WDATA && op_q == OP_WRB) begin
        if (addr_q[SUB_W-1:0] == SUB_END) state_q <= ST_CMD;
        else                              addr_q  <= addr_q + 1'b1;
      end
    end
  end

  assign sd_oe     = oe_q;
  assign intf_mode = (state_q == ST_CMD) || (state_q == ST_WDATA) || (state_q == ST_RDATA);
  assign locked    = (state_q == ST_LOCK);
  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;
  assign reg_we    = we_q;

  // R2: a lock is permanent until reset
  p_lock_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOCK) |=> (state_q == ST_LOCK));
  // R10: after exit no write strobe ever appears
  p_exit_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EXIT) |=> ((state_q == ST_EXIT) && !we_q));
  // R7: the write strobe lasts one cycle
  p_we_single_r7: assert property (@(posedge clk) disable iff (rst)
    we_q |=> !we_q);
  // R12: driver stays on while waiting for the first command
  p_oe_first_r12: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT) |-> oe_q);
  // R5: continuous read keeps its address
  p_rdc_addr_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RDATA && op_q == OP_RDC) |=> ($stable(addr_q) && state_q == ST_RDATA));
  // R6: block read ends at the sub-block boundary
  p_blk_end_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RDATA && op_q == OP_RDB && tx_done && addr_q[SUB_W-1:0] == SUB_END)
      |=> (state_q == ST_CMD));
  // R11: window expiry before a command locks the port
  p_win_lock_r11: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && win_expired) |=> (state_q == ST_LOCK));
endmodule

// File: tb/test_tw_reg_link.sv
module test_tw_reg_link;
  localparam int HALF = 5;
  localparam int GAP  = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        sclk = 1'b1;
  logic        sd_in = 1'b1;
  logic        sd_out, sd_oe, intf_mode, locked, reg_we;
  logic [5:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;

  logic [15:0] mem [64];
  logic [15:0] exp_mem [64];
  logic        fill_en = 1'b0;
  logic [31:0] fill_seed = 32'h0;
  int          we_cnt = 0;
  int          exp_we = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  logic        oe_mid;

  always #5 clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  tw_reg_link #(.WIN_TICKS(300), .SYNC_STAGES(2)) i_tw_reg_link (
    .clk(clk), .rst(rst), .tick(tick), .sclk(sclk), .sd_in(sd_in),
    .sd_out(sd_out), .sd_oe(sd_oe), .intf_mode(intf_mode), .locked(locked),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata)
  );

  function automatic logic [15:0] fill_val(input int i, input logic [31:0] s);
    return 16'((s ^ (32'(i) * 32'h9E37_79B9)) >> 7);
  endfunction

  always @(posedge clk) begin
    if (fill_en) begin
      for (int i = 0; i < 64; i++) mem[i] <= fill_val(i, fill_seed);
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      we_cnt <= we_cnt + 1;
    end
  end
  assign reg_rdata = mem[reg_addr];

  function automatic logic [20:0] fix_par(input logic [20:0] f);
    logic [20:0] g;
    logic e, o;
    g = f; g[17] = 1'b0; g[18] = 1'b0; e = 1'b0; o = 1'b0;
    for (int i = 0; i < 21; i++) begin
      if (i % 2 == 0) e ^= g[i];
      else            o ^= g[i];
    end
    g[17] = o;
    g[18] = e;
    return g;
  endfunction

  function automatic logic [20:0] mk_cmd(input logic [5:0] c, input logic [5:0] a);
    logic [20:0] f;
    f = '0; f[0] = 1'b1; f[6:1] = c; f[8] = 1'b1; f[14:9] = a; f[19] = 1'b1; f[20] = 1'b1;
    return fix_par(f);
  endfunction

  function automatic logic [20:0] mk_dat(input logic [15:0] d);
    logic [20:0] f;
    f = '0; f[0] = 1'b1; f[16:1] = d; f[20] = 1'b1;
    return fix_par(f);
  endfunction

  function automatic logic [20:0] exp_rd(input logic [5:0] a, input logic [15:0] d);
    return {1'b1, a[2:0], d, 1'b1};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic send_frame(input logic [20:0] f);
    for (int i = 0; i < 21; i++) begin
      sd_in = f[i];
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      if (i == 10) oe_mid = sd_oe;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    sd_in = 1'b1;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic recv_frame(output logic [20:0] f);
    for (int i = 0; i < 21; i++) begin
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      f[i] = sd_out;
      if (i == 10) oe_mid = sd_oe;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    repeat (GAP) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; sclk = 1'b1; sd_in = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr1(input logic [5:0] a, input logic [15:0] d);
    send_frame(mk_cmd(6'h09, a));
    send_frame(mk_dat(d));
    exp_mem[a] = d; exp_we++;
  endtask

  task automatic rd1(input logic [5:0] a, input string tag);
    logic [20:0] f;
    send_frame(mk_cmd(6'h01, a));
    recv_frame(f);
    chk(tag, 32'(f), 32'(exp_rd(a, exp_mem[a])));
  endtask

  initial begin
    logic [20:0] f;
    logic [5:0]  a;
    logic [15:0] d;
    int          n, k;
    int          we0;
    void'($urandom(32'd20240611));
    fill_seed = $urandom;
    for (int i = 0; i < 64; i++) exp_mem[i] = fill_val(i, fill_seed);
    @(negedge clk); fill_en = 1'b1; @(negedge clk); fill_en = 1'b0;
    do_reset();

    // Reset state
    chk("R12 reset sd_oe", 32'(sd_oe), 1);
    chk("R4 reset sd_out idle", 32'(sd_out), 1);
    chk("R10 reset intf_mode", 32'(intf_mode), 0);
    chk("R2 reset locked", 32'(locked), 0);

    // First frame: driver stays on, then single write
    send_frame(mk_cmd(6'h09, 6'h05));
    chk("R12 oe during first frame", 32'(oe_mid), 1);
    chk("R1 first command accepted", 32'(intf_mode), 1);
    d = 16'hA5C3;
    send_frame(mk_dat(d));
    exp_mem[5] = d; exp_we++;
    chk("R12 oe low during host frame", 32'(oe_mid), 0);
    chk("R12 oe on between frames", 32'(sd_oe), 1);
    chk("R7 single write data", 32'(mem[5]), 32'(d));
    chk("R7 one strobe", 32'(we_cnt), 32'(exp_we));
    send_frame(mk_cmd(6'h01, 6'h05));
    recv_frame(f);
    chk("R4 single read frame", 32'(f), 32'(exp_rd(6'h05, d)));
    chk("R12 oe on during read frame", 32'(oe_mid), 1);

    // R8: continuous write ended by a command
    send_frame(mk_cmd(6'h0A, 6'h21));
    for (int j = 0; j < 3; j++) begin
      d = 16'(32'h1111 * (j + 1));
      send_frame(mk_dat(d));
      exp_mem[6'h21] = d; exp_we++;
    end
    chk("R8 continuous write count", 32'(we_cnt), 32'(exp_we));
    rd1(6'h21, "R8 continuous write last value");
    chk("R8 command ends continuous write", 32'(locked), 0);

    // R9: block write cancelled after two frames
    send_frame(mk_cmd(6'h0B, 6'h10));
    send_frame(mk_dat(16'h0BEE)); exp_mem[6'h10] = 16'h0BEE; exp_we++;
    send_frame(mk_dat(16'h0BEF)); exp_mem[6'h11] = 16'h0BEF; exp_we++;
    rd1(6'h12, "R9 cancelled block left next word");
    rd1(6'h11, "R9 block write increments");

    // R6: block read across the boundary from 0x2D
    send_frame(mk_cmd(6'h03, 6'h2D));
    for (int j = 0; j < 3; j++) begin
      recv_frame(f);
      chk("R6 block read frame", 32'(f), 32'(exp_rd(6'(45 + j), exp_mem[45 + j])));
    end
    rd1(6'h30, "R6 command accepted after block end");

    // Random mix
    for (int it = 0; it < 30; it++) begin
      a = 6'($urandom_range(0, 63));
      case ($urandom_range(0, 4))
        0: wr1(a, 16'($urandom));
        1: rd1(a, "R4 random single read");
        2: begin
          send_frame(mk_cmd(6'h0A, a));
          k = $urandom_range(1, 3);
          for (int j = 0; j < k; j++) begin
            d = 16'($urandom);
            send_frame(mk_dat(d)); exp_mem[a] = d; exp_we++;
          end
        end
        3: begin
          send_frame(mk_cmd(6'h0B, a));
          n = 8 - int'(a[2:0]);
          k = $urandom_range(1, n);
          for (int j = 0; j < k; j++) begin
            d = 16'($urandom);
            send_frame(mk_dat(d)); exp_mem[6'(a + j)] = d; exp_we++;
          end
        end
        default: begin
          send_frame(mk_cmd(6'h03, a));
          n = 8 - int'(a[2:0]);
          for (int j = 0; j < n; j++) begin
            recv_frame(f);
            chk("R6 random block read", 32'(f), 32'(exp_rd(6'(a + j), exp_mem[6'(a + j)])));
          end
        end
      endcase
    end
    chk("R7 strobe total after random mix", 32'(we_cnt), 32'(exp_we));
    for (int i = 0; i < 64; i += 9) chk("R9 memory image", 32'(mem[i]), 32'(exp_mem[i]));

    // R9: full block write stops, extra data frame locks
    send_frame(mk_cmd(6'h0B, 6'h1E));
    send_frame(mk_dat(16'h7001)); exp_mem[6'h1E] = 16'h7001; exp_we++;
    send_frame(mk_dat(16'h7002)); exp_mem[6'h1F] = 16'h7002; exp_we++;
    send_frame(mk_dat(16'h7003));
    chk("R9 data after block end locks", 32'(locked), 1);
    chk("R9 no write past block end", 32'(mem[6'h20]), 32'(exp_mem[6'h20]));
    chk("R2 intf_mode cleared on lock", 32'(intf_mode), 0);

    // R5: continuous read stays on its address
    do_reset();
    send_frame(mk_cmd(6'h02, 6'h09));
    for (int j = 0; j < 3; j++) begin
      sd_in = 1'b0;
      recv_frame(f);
      chk("R5 continuous read frame", 32'(f), 32'(exp_rd(6'h09, exp_mem[9])));
    end
    chk("R5 still in interface mode", 32'(intf_mode), 1);

    // R2: bad parity locks, later frames ignored
    do_reset();
    rd1(6'h07, "R4 read after reset");
    f = mk_cmd(6'h09, 6'h07); f[17] = ~f[17];
    send_frame(f);
    chk("R2 bad parity locks", 32'(locked), 1);
    we0 = we_cnt;
    send_frame(mk_cmd(6'h09, 6'h07)); send_frame(mk_dat(16'hDEAD));
    chk("R2 locked port ignores writes", 32'(we_cnt), 32'(we0));

    // R2: bad end marker
    do_reset();
    f = mk_cmd(6'h01, 6'h02); f[20] = 1'b0; f = fix_par(f);
    send_frame(f);
    chk("R2 bad end marker locks", 32'(locked), 1);

    // R2: data frame as first frame
    do_reset();
    send_frame(mk_dat(16'h1234));
    chk("R2 data frame without command locks", 32'(locked), 1);

    // R3: unknown code and bad fixed bit
    do_reset();
    send_frame(mk_cmd(6'h05, 6'h01));
    chk("R3 unknown code locks", 32'(locked), 1);
    do_reset();
    f = mk_cmd(6'h01, 6'h01); f[8] = 1'b0; f = fix_par(f);
    send_frame(f);
    chk("R3 bad fixed bit locks", 32'(locked), 1);

    // R7: command instead of the single-write data frame
    do_reset();
    send_frame(mk_cmd(6'h09, 6'h03));
    send_frame(mk_cmd(6'h01, 6'h03));
    chk("R7 command after single write locks", 32'(locked), 1);

    // R10: exit
    do_reset();
    send_frame(mk_cmd(6'h00, 6'h00));
    chk("R10 exit clears intf_mode", 32'(intf_mode), 0);
    chk("R10 exit is not a lock", 32'(locked), 0);
    we0 = we_cnt;
    send_frame(mk_cmd(6'h09, 6'h04)); send_frame(mk_dat(16'hBEEF));
    chk("R10 no writes after exit", 32'(we_cnt), 32'(we0));

    // R11: power-up window expiry
    do_reset();
    repeat (700) @(negedge clk);
    chk("R11 window expiry locks", 32'(locked), 1);
    we0 = we_cnt;
    send_frame(mk_cmd(6'h09, 6'h04)); send_frame(mk_dat(16'hCAFE));
    chk("R11 no writes after expiry", 32'(we_cnt), 32'(we0));
    chk("R11 memory untouched", 32'(mem[4]), 32'(exp_mem[4]));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end
endmodule